// File: doc/BRIEF.md
# Idle-Synchronized Stream Descrambler

This block turns a scrambled 100 Mbps serial stream back into 5-bit code groups. The stream reaches it after MLT-3 decoding, one bit per cycle of a bit-rate clock enable. The far-end scrambler keystream comes from an 11-bit linear feedback shift register with polynomial x^11 + x^9 + 1. The local copy of that register is not seeded by reset. It is acquired from the line while the line carries idle, which is a continuous run of plaintext ones. In that state every received bit, inverted, is the keystream bit itself.

Lock is declared once a long enough run of received bits matches the keystream the register predicts. Lock is held while idle keeps appearing, and it is dropped when a whole supervision window passes with no long idle run. Symbol framing comes from the moment of lock: each group of five descrambled bits after it is one code group, and each group comes out with a one-cycle strobe.

Top module: `idle_sync_descrambler`

## Requirements
- R1: After reset `locked`, `sym_valid` and `sym` are all 0.
- R2: The keystream bit is s[10] XOR s[8] of the 11-bit register s, whose next state is {s[9:0], key}. While locked, the descrambled bit is `rx_bit` XOR key, so the emitted groups equal the plaintext the far end scrambled.
- R3: While unlocked, the register shifts in the inverted received bit. A bit agrees when its inverse equals the predicted key. `locked` rises after the 60th consecutive agreeing bit. On a clean scrambled idle stream started after reset this is bit index 59 to 70, counting from 0.
- R4: Any disagreeing bit restarts the agreement count. A stream with no scrambled-idle structure never locks. After a single corrupted bit at index f of an idle stream, lock comes at index f+60 to f+71.
- R5: The first bit processed while locked is the first bit of a group. The earliest received bit of a group lands in `sym[4]` and the latest in `sym[0]`. One group completes every 5 locked bits.
- R6: `sym_valid` is high for exactly one clock cycle per group, and only on a bit that was processed while locked.
- R7: A cycle with `bit_en` low changes neither the register, `locked` nor `sym`.
- R8: While locked, locked bits are counted in windows of WINDOW_BITS. A window that contains a run of at least 30 consecutive descrambled ones keeps the lock.
- R9: A window with no such run drops `locked` on its last bit, which is locked bit index WINDOW_BITS-1 within the window. Runs of 29 ones are not enough.
- R10: After lock is dropped, acquisition restarts from a zero agreement count. On continuing idle, lock returns exactly 60 bits after the dropping bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle pulse per received bit |
| rx_bit | input | 1 | Scrambled serial bit after MLT-3 decoding |
| sym | output | 5 | Last recovered code group, earliest bit in bit 4 |
| sym_valid | output | 1 | One-cycle strobe when `sym` is updated |
| locked | output | 1 | Descrambler is synchronized to the far end |

## Verification
The bench aims at the acquisition boundaries. It checks that lock comes no sooner than 60 agreeing bits and no later than fill plus 60, both on a clean stream and after a single corrupted bit. A design that did not restart its count on a mismatch would lock too early, and one that seeded from a fixed value would never lock. Supervision is probed at the 29/30 run-length edge and at the exact window-end bit. An off-by-one window or run threshold would move or suppress the drop. Group framing and bit order are checked against bench plaintext for every strobe, so a shifted frame or a reversed group shows up as a wrong `sym`.

// File: rtl/idle_sync_descrambler.sv
module idle_sync_descrambler #(
  parameter int LOCK_RUN    = 60,
  parameter int HOLD_RUN    = 30,
  parameter int WINDOW_BITS = 125000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       rx_bit,
  output logic [4:0] sym,
  output logic       sym_valid,
  output logic       locked
);
  localparam int AW = $clog2(LOCK_RUN + 1);
  localparam int HW = $clog2(HOLD_RUN + 1);
  localparam int WW = $clog2(WINDOW_BITS + 1);

  logic [10:0]   lfsr;
  logic [AW-1:0] agree_cnt;
  logic [HW-1:0] run_cnt;
  logic [WW-1:0] win_cnt;
  logic          seen;
  logic [2:0]    pos;
  logic [3:0]    shreg;

  wire key     = lfsr[10] ^ lfsr[8];
  wire plain   = rx_bit ^ key;
  wire win_end = (win_cnt == WW'(WINDOW_BITS - 1));
  wire run_hit = plain && (run_cnt >= HW'(HOLD_RUN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr      <= '0;
      agree_cnt <= '0;
      run_cnt   <= '0;
      win_cnt   <= '0;
      seen      <= 1'b0;
      pos       <= '0;
      shreg     <= '0;
      sym       <= '0;
      sym_valid <= 1'b0;
      locked    <= 1'b0;
    end else begin
      sym_valid <= 1'b0;
      if (bit_en) begin
        if (!locked) begin
          lfsr    <= {lfsr[9:0], ~rx_bit};
          pos     <= '0;
          win_cnt <= '0;
          seen    <= 1'b0;
          run_cnt <= '0;
          if (!plain)
            agree_cnt <= '0;
          else if (agree_cnt == AW'(LOCK_RUN - 1)) begin
            agree_cnt <= '0;
            locked    <= 1'b1;
          end else
            agree_cnt <= agree_cnt + 1'b1;
        end else begin
          lfsr    <= {lfsr[9:0], key};
          run_cnt <= !plain ? '0 : (run_hit ? HW'(HOLD_RUN) : run_cnt + 1'b1);
          if (pos == 3'd4) begin
            sym       <= {shreg, plain};
            sym_valid <= 1'b1;
            pos       <= '0;
          end else begin
            shreg <= {shreg[2:0], plain};
            pos   <= pos + 1'b1;
          end
          if (win_end) begin
            win_cnt <= '0;
            seen    <= 1'b0;
            if (!(seen || run_hit)) locked <= 1'b0;
          end else begin
            win_cnt <= win_cnt + 1'b1;
            if (run_hit) seen <= 1'b1;
          end
        end
      end
    end
  end

  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |=> !sym_valid);
  p_valid_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> $past(locked));
  p_lock_after_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(agree_cnt) == AW'(LOCK_RUN - 1)) && $past(bit_en));
  p_drop_at_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(win_end) && !$past(seen));
  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(lfsr) && $stable(locked) && $stable(sym));
endmodule

// File: tb/test_idle_sync_descrambler.sv
module test_idle_sync_descrambler;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 200;

  logic clk = 0, rst_n = 0, bit_en = 0, rx_bit = 0;
  logic [4:0] sym;
  logic sym_valid, locked;

  int checks = 0, fails = 0;
  logic [10:0] ts;
  logic hist [0:4095];
  int n, rise_n, fall_n, rises, falls;
  logic prev_lk;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idle_sync_descrambler #(.LOCK_RUN(60), .HOLD_RUN(30), .WINDOW_BITS(WIN)) i_idle_sync_descrambler (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .sym(sym), .sym_valid(sym_valid), .locked(locked));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic start_run(input logic [10:0] seed);
    @(negedge clk);
    rst_n = 0; bit_en = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    ts = seed; n = 0; rises = 0; falls = 0; rise_n = -1; fall_n = -1; prev_lk = 0;
  endtask

  task automatic send_bit(input logic p, input logic flip, input logic raw);
    logic k, lk, v;
    logic [4:0] s, e;
    k = ts[10] ^ ts[8];
    ts = {ts[9:0], k};
    rx_bit = raw ? p : (p ^ k ^ flip);
    bit_en = 1;
    hist[n] = p;
    @(negedge clk);
    bit_en = 0;
    lk = locked; v = sym_valid; s = sym;
    if (lk && !prev_lk) begin rise_n = n; rises++; end
    if (!lk && prev_lk) begin fall_n = n; falls++; end
    if (v) begin
      check(prev_lk, "R6 strobe only on a locked bit", 0, 1);
      check(((n - rise_n - 1) % 5) == 4, "R5 group framing", (n - rise_n - 1) % 5, 4);
      if (n >= 4) begin
        e = {hist[n-4], hist[n-3], hist[n-2], hist[n-1], hist[n]};
        check(s == e, "R2 descrambled group", s, e);
      end
    end
    @(negedge clk);
    if (v) check(sym_valid == 0, "R6 strobe lasts one cycle", sym_valid, 0);
    check(locked == lk && sym == s, "R7 idle cycle holds state", locked, lk);
    prev_lk = lk;
    n++;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    check(0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    logic [31:0] r;
    int lk_at, gl, d, hold_ok, vcnt;
    // R1 reset state
    start_run(11'h5A3);
    check(locked == 0 && sym_valid == 0 && sym == 0, "R1 reset state", {locked, sym_valid, sym}, 0);

    // R4: unstructured data never locks
    r = 32'h1234_5678;
    vcnt = 0;
    for (int i = 0; i < 300; i++) begin
      r ^= r << 13; r ^= r >> 17; r ^= r << 5;
      send_bit(r[0], 0, 1);
      if (prev_lk) vcnt++;
    end
    check(rises == 0 && vcnt == 0, "R4 random stream stays unlocked", rises, 0);

    // R3: clean idle acquisition
    start_run(11'h3C7);
    for (int i = 0; i < 150 && rises == 0; i++) send_bit(1, 0, 0);
    lk_at = rise_n;
    check(rises == 1 && lk_at >= 59 && lk_at <= 70, "R3 lock index on clean idle", lk_at, 59);

    // R4: glitch restarts agreement
    start_run(11'h1F0);
    gl = 30;
    for (int i = 0; i < 200 && rises == 0; i++) send_bit(1, (i == gl), 0);
    lk_at = rise_n;
    check(rises == 1 && lk_at >= gl + 60 && lk_at <= gl + 71, "R4 lock after corrupted bit", lk_at, gl + 60);

    // R2/R5: data groups after lock
    for (int j = 0; j < 32; j++) begin
      logic [4:0] v5;
      v5 = 5'((j * 13 + 5) & 31);
      for (int b = 4; b >= 0; b--) send_bit(v5[b], 0, 0);
    end
    for (int i = 0; i < 40; i++) send_bit(1, 0, 0);
    // R8: runs of 30 keep the lock
    for (int i = 0; i < 600; i++) send_bit((i % 31) != 30, 0, 0);
    hold_ok = (falls == 0 && locked == 1) ? 1 : 0;
    check(hold_ok == 1, "R8 lock held by 30-bit runs", falls, 0);
    // R9: runs of 29 only, drop at window end
    for (int i = 0; i < 200; i++) send_bit((i % 30) != 0, 0, 0);
    d = lk_at + 5 * WIN;
    check(falls == 1 && fall_n == d, "R9 drop on window end bit", fall_n, d);
    // R10: relock exactly 60 bits later
    for (int i = 0; i < 80; i++) send_bit(1, 0, 0);
    check(rises == 2 && rise_n == d + 60, "R10 relock after drop", rise_n, d + 60);
    check(locked == 1, "R10 locked after relock", locked, 1);

    finish_up();
  end
endmodule